// File: doc/BRIEF.md
# Network Controller Status Flag Register

This block keeps the status byte of a token-passing network controller and drives the controller's level interrupt. The host issues one-cycle command strobes: start reception into a page, start transmission from a page, stop the transmitter, and clear flags. The link engine sends one-cycle event pulses: a packet was stored, the token arrived, the final byte went out, an acknowledge came back, a software reset ran, or the node ID register was written. Each status flag has its own set and clear events. When a set and a clear land in the same cycle, the set wins.

The block also watches the raw receive line. An internal idle counter restarts on every edge of the line. After the line has been quiet for a parameterised number of clock cycles, the counter raises the reconfiguration flag once. While reception is inhibited, the block asks the link engine to answer incoming packets with a negative acknowledge. The interrupt output is the OR of three flags, each gated by its bit in the host-supplied mask.

The asynchronous reset is released in step with the clock. The raw line is brought into the clock domain through a short synchroniser chain.

Top module: `netstat_flags`

## Requirements
- R1: Status bit positions are fixed: bit 7 receive-blocked, bit 4 reset-seen, bit 2 reconfiguration, bit 1 transmit-acknowledged, bit 0 transmitter-free. Bits 6, 5 and 3 always read 0.
- R2: Receive-blocked is 1 after reset and is set in the cycle after a packet-stored pulse. It is cleared only by the receive-enable command.
- R3: The NAK-request output is high exactly when receive-blocked is set.
- R4: Reset-seen is 1 after reset and is set by a software-reset pulse or by a node ID write whose data is 00h. A nonzero node ID write leaves it unchanged. Only clear-flags clears it.
- R5: Reconfiguration is set once the receive line has had no edge for IDLE_CYCLES clock cycles, give or take the synchroniser latency of a few cycles. It is cleared by clear-flags.
- R6: Each quiet period raises reconfiguration at most once. After a clear, the flag stays 0 until the line toggles and then goes quiet again for the full threshold.
- R7: Transmit-acknowledged is set by an acknowledge pulse unless the broadcast input is high with it. It is cleared by the transmit-enable command.
- R8: Transmitter-free is 1 after reset and is set by a last-byte pulse or by the transmitter-disable command. After a transmit-enable, the first token pulse clears it. A token pulse with no transmit-enable pending, or after a disable, leaves it set.
- R9: The interrupt is high exactly when status bits 7, 2 or 0 AND the matching mask bit is nonzero. Mask bits 4 and 1 have no effect.
- R10: When a set event and its clear command occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rx_enable | input | 1 | Host command: enable reception into a page |
| cmd_tx_enable | input | 1 | Host command: enable transmission from a page |
| cmd_tx_disable | input | 1 | Host command: disable transmitter |
| cmd_clear_flags | input | 1 | Host command: clear reset-seen and reconfiguration |
| ev_pkt_stored | input | 1 | Packet written into the receive page |
| ev_token | input | 1 | Token received by this node |
| ev_last_byte | input | 1 | Final byte of the scheduled packet sent |
| ev_ack | input | 1 | Acknowledge received for the sent packet |
| tx_broadcast | input | 1 | The sent packet was a broadcast (qualifies ev_ack) |
| ev_soft_reset | input | 1 | Software reset executed |
| node_id_wr | input | 1 | Node ID register write strobe |
| node_id_data | input | 8 | Data written to the node ID register |
| rx_line | input | 1 | Raw receive line (asynchronous) |
| irq_mask | input | 8 | Interrupt mask, same bit positions as status |
| status | output | 8 | Status byte |
| irq | output | 1 | Level interrupt |
| nak_req | output | 1 | Request to NAK incoming packets |

## Verification
The hardest case to reach is the single-shot reconfiguration: the line must stay quiet well past the threshold, the flag must be cleared, and the quiet period must then continue long enough to prove the flag does not return. The bench runs a background process that toggles the line during every other test. It stops the toggling for the idle tests and samples the flag in a window that allows for the synchroniser latency. A clear-flags command is then issued, the line is held quiet for twice the threshold, and the line is toggled again to show that a fresh quiet period re-arms the timer. The pending-token clear of transmitter-free is reached by sending tokens both with and without a preceding transmit-enable.

// File: rtl/netstat_pkg.sv
package netstat_pkg;
  localparam int STAT_W    = 8;
  localparam int BIT_RXBLK = 7;
  localparam int BIT_RSTSN = 4;
  localparam int BIT_TEST  = 3;
  localparam int BIT_RECFG = 2;
  localparam int BIT_TXACK = 1;
  localparam int BIT_TXFRE = 0;
  localparam logic [STAT_W-1:0] IRQ_SRC = 8'h85;

  typedef struct packed {
    logic rxblk;
    logic rstsn;
    logic recfg;
    logic txack;
    logic txfre;
  } flags_t;
endpackage

// File: rtl/netstat_sync.sv
module netstat_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_rest
        assign stage_d = chain[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= stage_d;
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/netstat_flag_cell.sv
module netstat_flag_cell #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_en;
  logic q_d;

  // set has priority over clear
  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RST_VAL;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/netstat_idle_timer.sv
module netstat_idle_timer #(
  parameter int LIMIT       = 4100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic timeout_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(LIMIT);
  localparam logic [CW-1:0] CNT_FIRE = CW'(LIMIT - 1);

  logic          line_s;
  logic          line_q;
  logic          line_edge;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  netstat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_s;
  end

  always_comb begin
    line_edge = line_s ^ line_q;
    cnt_en    = line_edge | (cnt_q != CNT_MAX);
    cnt_d     = line_edge ? '0 : cnt_q + 1'b1;
    timeout_o = !line_edge && (cnt_q == CNT_FIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/netstat_flags.sv
module netstat_flags
  import netstat_pkg::*;
#(
  parameter int IDLE_CYCLES = 4100,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_rx_enable,
  input  logic        cmd_tx_enable,
  input  logic        cmd_tx_disable,
  input  logic        cmd_clear_flags,
  input  logic        ev_pkt_stored,
  input  logic        ev_token,
  input  logic        ev_last_byte,
  input  logic        ev_ack,
  input  logic        tx_broadcast,
  input  logic        ev_soft_reset,
  input  logic        node_id_wr,
  input  logic [7:0]  node_id_data,
  input  logic        rx_line,
  input  logic [7:0]  irq_mask,
  output logic [7:0]  status,
  output logic        irq,
  output logic        nak_req
);
  logic   rst_sync_n;
  logic   idle_timeout;
  flags_t fset;
  flags_t fclr;
  flags_t fq;
  logic   tx_pend_q;
  logic   tx_pend_d;
  logic   tx_pend_en;

  netstat_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  netstat_idle_timer #(.LIMIT(IDLE_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_idle (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .line_i    (rx_line),
    .timeout_o (idle_timeout)
  );

  // token-clear arming after a transmit enable
  always_comb begin
    tx_pend_en = cmd_tx_disable | cmd_tx_enable | ev_token;
    if (cmd_tx_disable)     tx_pend_d = 1'b0;
    else if (cmd_tx_enable) tx_pend_d = 1'b1;
    else                    tx_pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     tx_pend_q <= 1'b0;
    else if (tx_pend_en) tx_pend_q <= tx_pend_d;
  end

  always_comb begin
    fset.rxblk = ev_pkt_stored;
    fclr.rxblk = cmd_rx_enable;
    fset.rstsn = ev_soft_reset | (node_id_wr && (node_id_data == 8'h00));
    fclr.rstsn = cmd_clear_flags;
    fset.recfg = idle_timeout;
    fclr.recfg = cmd_clear_flags;
    fset.txack = ev_ack & ~tx_broadcast;
    fclr.txack = cmd_tx_enable;
    fset.txfre = ev_last_byte | cmd_tx_disable;
    fclr.txfre = ev_token & tx_pend_q;
  end

  netstat_flag_cell #(.RST_VAL(1'b1)) u_rxblk (
    .clk(clk), .rst_n(rst_sync_n), .set_i(fset.rxblk), .clr_i(fclr.rxblk), .q_o(fq.rxblk));
  netstat_flag_cell #(.RST_VAL(1'b1)) u_rstsn (
    .clk(clk), .rst_n(rst_sync_n), .set_i(fset.rstsn), .clr_i(fclr.rstsn), .q_o(fq.rstsn));
  netstat_flag_cell #(.RST_VAL(1'b0)) u_recfg (
    .clk(clk), .rst_n(rst_sync_n), .set_i(fset.recfg), .clr_i(fclr.recfg), .q_o(fq.recfg));
  netstat_flag_cell #(.RST_VAL(1'b0)) u_txack (
    .clk(clk), .rst_n(rst_sync_n), .set_i(fset.txack), .clr_i(fclr.txack), .q_o(fq.txack));
  netstat_flag_cell #(.RST_VAL(1'b1)) u_txfre (
    .clk(clk), .rst_n(rst_sync_n), .set_i(fset.txfre), .clr_i(fclr.txfre), .q_o(fq.txfre));

  always_comb begin
    status            = '0;
    status[BIT_RXBLK] = fq.rxblk;
    status[BIT_RSTSN] = fq.rstsn;
    status[BIT_TEST]  = 1'b0;
    status[BIT_RECFG] = fq.recfg;
    status[BIT_TXACK] = fq.txack;
    status[BIT_TXFRE] = fq.txfre;
    irq               = |(status & irq_mask & IRQ_SRC);
    nak_req           = fq.rxblk;
  end
endmodule

// File: rtl/netstat_flags_checker.sv
module netstat_flags_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_rx_enable,
  input logic       cmd_tx_enable,
  input logic       cmd_tx_disable,
  input logic       cmd_clear_flags,
  input logic       ev_pkt_stored,
  input logic       ev_ack,
  input logic       tx_broadcast,
  input logic       ev_last_byte,
  input logic [7:0] irq_mask,
  input logic [7:0] status,
  input logic       irq,
  input logic       nak_req
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] == 1'b0) && (status[5] == 1'b0) && (status[3] == 1'b0)); // R1
  AST_PKT_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt_stored |=> status[7]); // R2
  AST_RXEN_UNBLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rx_enable && !ev_pkt_stored) |=> !status[7]); // R2
  AST_NAK_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    nak_req == status[7]); // R3
  AST_RSTSN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !cmd_clear_flags) |=> status[4]); // R4
  AST_BCAST_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[1] && ev_ack && tx_broadcast) |=> !status[1]); // R7
  AST_TXFREE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_last_byte || cmd_tx_disable) |=> status[0]); // R8
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((status[7] & irq_mask[7]) | (status[2] & irq_mask[2]) | (status[0] & irq_mask[0]))); // R9
endmodule

bind netstat_flags netstat_flags_checker u_chk (.*);

// File: tb/netstat_flags_bench.sv
module netstat_flags_bench;
  localparam int IDLE = 24;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_rx_enable, cmd_tx_enable, cmd_tx_disable, cmd_clear_flags;
  logic       ev_pkt_stored, ev_token, ev_last_byte, ev_ack, tx_broadcast;
  logic       ev_soft_reset, node_id_wr;
  logic [7:0] node_id_data;
  logic       rx_line;
  logic [7:0] irq_mask;
  logic [7:0] status;
  logic       irq, nak_req;

  always #5 clk = ~clk;

  netstat_flags #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) u_netstat_flags (
    .clk(clk), .rst_n(rst_n),
    .cmd_rx_enable(cmd_rx_enable), .cmd_tx_enable(cmd_tx_enable),
    .cmd_tx_disable(cmd_tx_disable), .cmd_clear_flags(cmd_clear_flags),
    .ev_pkt_stored(ev_pkt_stored), .ev_token(ev_token), .ev_last_byte(ev_last_byte),
    .ev_ack(ev_ack), .tx_broadcast(tx_broadcast), .ev_soft_reset(ev_soft_reset),
    .node_id_wr(node_id_wr), .node_id_data(node_id_data), .rx_line(rx_line),
    .irq_mask(irq_mask), .status(status), .irq(irq), .nak_req(nak_req));

  typedef struct {
    logic [7:0] st;
    logic       irq;
    logic       nak;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  bit   line_busy = 1'b1;

  // expected model flags
  logic e_rxblk, e_rstsn, e_recfg, e_txack, e_txfre;

  // background line activity
  initial begin
    rx_line = 1'b0;
    forever begin
      repeat (3) @(posedge clk);
      if (line_busy) rx_line = ~rx_line;
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        n_cmp++;
        if (status !== it.st || irq !== it.irq || nak_req !== it.nak) begin
          n_bad++;
          $display("FAIL %s: status=%h irq=%b nak=%b expected status=%h irq=%b nak=%b",
                   it.tag, status, irq, nak_req, it.st, it.irq, it.nak);
        end
      end
    end
  end

  task automatic expect_now(input string tag);
    exp_t it;
    it.st  = {e_rxblk, 2'b00, e_rstsn, 1'b0, e_recfg, e_txack, e_txfre};
    it.irq = (e_rxblk & irq_mask[7]) | (e_recfg & irq_mask[2]) | (e_txfre & irq_mask[0]);
    it.nak = e_rxblk;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic clear_strobes();
    cmd_rx_enable = 0; cmd_tx_enable = 0; cmd_tx_disable = 0; cmd_clear_flags = 0;
    ev_pkt_stored = 0; ev_token = 0; ev_last_byte = 0; ev_ack = 0; tx_broadcast = 0;
    ev_soft_reset = 0; node_id_wr = 0; node_id_data = 8'h00;
  endtask

  // apply strobes for exactly one clock edge
  task automatic go();
    @(posedge clk);
    #1;
    clear_strobes();
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_strobes();
    irq_mask = 8'h00;
    e_rxblk = 1; e_rstsn = 1; e_recfg = 0; e_txack = 0; e_txfre = 1;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    expect_now("R1 R2 R4 R8 reset state");

    irq_mask = 8'h80;
    expect_now("R9 mask rx-blocked");
    irq_mask = 8'h12;
    expect_now("R9 mask bits 4 and 1 inert");

    cmd_rx_enable = 1; go(); e_rxblk = 0;
    expect_now("R2 R3 receive enable clears");
    ev_pkt_stored = 1; go(); e_rxblk = 1;
    expect_now("R2 R3 packet stored blocks");
    cmd_rx_enable = 1; go(); e_rxblk = 0;
    ev_pkt_stored = 1; cmd_rx_enable = 1; go(); e_rxblk = 1;
    expect_now("R10 R2 set beats receive enable");

    cmd_clear_flags = 1; go(); e_rstsn = 0;
    expect_now("R4 clear flags clears reset-seen");
    node_id_wr = 1; node_id_data = 8'h5A; go();
    expect_now("R4 nonzero node id ignored");
    node_id_wr = 1; node_id_data = 8'h00; go(); e_rstsn = 1;
    expect_now("R4 zero node id sets");
    cmd_clear_flags = 1; go(); e_rstsn = 0;
    ev_soft_reset = 1; go(); e_rstsn = 1;
    expect_now("R4 software reset sets");
    ev_soft_reset = 1; cmd_clear_flags = 1; go();
    expect_now("R10 R4 set beats clear flags");

    irq_mask = 8'h01;
    ev_ack = 1; tx_broadcast = 1; go();
    expect_now("R7 broadcast ack ignored");
    cmd_tx_enable = 1; go();
    expect_now("R8 enable alone keeps transmitter free");
    ev_ack = 1; go(); e_txack = 1;
    expect_now("R7 ack sets");
    ev_token = 1; go(); e_txfre = 0;
    expect_now("R8 token after enable clears, R9 irq low");
    ev_last_byte = 1; go(); e_txfre = 1;
    expect_now("R8 last byte sets");
    ev_token = 1; go();
    expect_now("R8 token without pending enable ignored");
    cmd_tx_enable = 1; go(); e_txack = 0;
    expect_now("R7 enable clears ack");
    cmd_tx_disable = 1; go();
    ev_token = 1; go();
    expect_now("R8 disable cancels pending clear");
    cmd_tx_enable = 1; ev_ack = 1; go(); e_txack = 1;
    expect_now("R10 R7 ack beats enable");
    ev_token = 1; go(); e_txfre = 0;
    ev_token = 1; ev_last_byte = 1; go(); e_txfre = 1;
    expect_now("R10 R8 last byte beats token");

    // idle timer
    irq_mask = 8'h04;
    line_busy = 0;
    idle(IDLE - 2);
    expect_now("R5 not yet reconfigured");
    idle(10);
    e_recfg = 1;
    expect_now("R5 idle sets reconfiguration, R9 irq");
    cmd_clear_flags = 1; go(); e_recfg = 0; e_rstsn = 0;
    expect_now("R5 clear flags clears reconfiguration");
    idle(2 * IDLE);
    expect_now("R6 single pulse per quiet period");
    line_busy = 1;
    idle(IDLE);
    expect_now("R6 activity keeps flag clear");
    line_busy = 0;
    idle(IDLE + 12);
    e_recfg = 1;
    expect_now("R6 new quiet period sets again");

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule